// File: doc/BRIEF.md
# Stereo Audio Port FIFO and Interrupt Front End

This block sits between a processor register bus and the serial engine of a stereo audio port. It holds a transmit queue and a receive queue, each sixteen words of 32 bits. One word carries a left and right pair of 16-bit samples. A single data address feeds both queues: a bus write appends to the transmit queue, and a bus read takes the oldest word from the receive queue. The serial engine takes words out of the transmit side with a one-cycle pop strobe and delivers captured words into the receive side with a push strobe.

Software sets the port up through four more addresses. A control word holds the link enable, the bit-clock direction, a soft reset, and two 4-bit fill thresholds. A mode word can turn playback and recording off independently. A mask word selects which conditions raise the interrupt. A clear address resets the sticky error flags when a 1 is written to the flag's bit. The status word reports the flags and the queue levels.

The block raises a transmit service request when the transmit queue is low and a receive service request when the receive queue is well filled. A DMA engine or an interrupt handler uses these to keep the queues moving. A single masked interrupt line combines all of the conditions.

Top module: `audio_fifo_port`

## Requirements
- R1: After reset, the control word (address 0) reads 0, the mode word (address 1) reads 0x18, the mask (address 3) reads 0, the status (address 2) reads 0x81, and the irq, tx_req and rx_req outputs are low.
- R2: A write to the data address (5) appends the word to the transmit queue. Successive tx_pop strobes present the words on tx_data, oldest first, one cycle after each strobe. A write made while sixteen words are queued is dropped. Status bit 0 reads 1 exactly when the transmit queue is not full.
- R3: A read of the data address returns the oldest received word on reg_rdata one cycle later and removes it from the queue. A read while the receive queue is empty returns 0 and changes nothing. Status bit 1 reads 1 while the receive queue holds a word.
- R4: Status bit 4, and one cycle later the rx_req output, are high while the link is on, recording is on, and the receive occupancy is at or above control bits 15:12.
- R5: Status bit 3, and one cycle later the tx_req output, are high while the link is on, playback is on, and the transmit occupancy is at or below control bits 11:8.
- R6: An rx_push accepted while the receive queue is full discards the word and sets the sticky overrun flag (status bit 6).
- R7: A tx_pop accepted while the transmit queue is empty drives tx_data to 0 and sets the sticky underrun flag (status bit 5).
- R8: Writing the clear address (4) with bit 6 set clears overrun, and with bit 5 set clears underrun. A flag whose bit is written 0 keeps its value.
- R9: The irq output is high one cycle after any status bit in the range 6 to 3 is high together with the mask bit at the same position.
- R10: While control bit 3 is set, both queues are emptied, and the mode word, the mask, the error flags and the other control fields return to their reset values.
- R11: tx_pop is ignored when control bit 0 (link enable) is 0 or mode bit 4 (playback off) is 1. rx_push is ignored when the link is off or mode bit 3 (recording off) is 1. Ignored strobes change no queue, no flag and no tx_data.
- R12: link_en follows control bit 0 and bclk_drive follows control bit 2. Status bit 7 is 1 while the link is off. Status bit 2 (busy) is 1 while the link is on and either direction is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address: 0 control, 1 mode, 2 status, 3 mask, 4 clear, 5 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| tx_pop | input | 1 | Serial engine takes one transmit word |
| tx_data | output | 32 | Transmit word, valid the cycle after tx_pop |
| rx_push | input | 1 | Serial engine delivers one received word |
| rx_data | input | 32 | Received word that goes with rx_push |
| tx_req | output | 1 | Transmit service request |
| rx_req | output | 1 | Receive service request |
| irq | output | 1 | Combined masked interrupt |
| link_en | output | 1 | Link enable to the serial engine |
| bclk_drive | output | 1 | 1 when the port drives the bit clock |

## Verification
The properties assume the bus raises at most one of reg_wr and reg_rd per cycle. They also assume the serial strobes are single-cycle pulses sampled at the clock edge. The stimulus drives every bus access as an isolated one-cycle strobe set up on the falling edge, and issues tx_pop and rx_push alone, never together with a bus access. The overrun and underrun checks rely on the serial side pushing into a full queue or popping from an empty one. The bench creates those cases on purpose with seventeen pushes and with pops after the queue has drained, with the link both on and off.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned TH_W   = 4;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_MASK = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CLR  = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_DATA = 3'd5;

  // control word bit positions
  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_BCK  = 2;
  localparam int unsigned C_SRST = 3;
  localparam int unsigned C_TTH  = 8;
  localparam int unsigned C_RTH  = 12;
  // mode word
  localparam int unsigned M_RDIS = 3;
  localparam int unsigned M_PDIS = 4;
  // status / mask / clear positions
  localparam int unsigned S_TNF  = 0;
  localparam int unsigned S_RNE  = 1;
  localparam int unsigned S_BSY  = 2;
  localparam int unsigned S_TSR  = 3;
  localparam int unsigned S_RSR  = 4;
  localparam int unsigned S_UDR  = 5;
  localparam int unsigned S_OVR  = 6;
  localparam int unsigned S_OFF  = 7;

  typedef struct packed {
    logic [TH_W-1:0] rx_th;
    logic [TH_W-1:0] tx_th;
    logic            srst;
    logic            bck;
    logic            en;
  } ctrl_t;
endpackage

// File: rtl/afp_fifo.sv
module afp_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             wr_ok, rd_ok;

  assign empty = (count == '0);
  assign full  = (count == CMAX);
  assign wr_ok = push && !full && !clr;
  assign rd_ok = pop && !empty && !clr;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      dout  <= '0;
    end else begin
      if (wr_ok) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (pop) dout <= rd_ok ? mem[rptr] : '0;
      if (rd_ok) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/afp_svc.sv
module afp_svc
  import audio_fifo_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   tx_cnt,
  input  logic [CW-1:0]   rx_cnt,
  input  logic [TH_W-1:0] tx_th,
  input  logic [TH_W-1:0] rx_th,
  input  logic            tx_act,
  input  logic            rx_act,
  input  logic            ovr,
  input  logic            udr,
  input  logic [3:0]      mask,
  output logic            tx_lvl,
  output logic            rx_lvl,
  output logic            tx_req,
  output logic            rx_req,
  output logic            irq
);
  logic [3:0] cond;

  assign rx_lvl = rx_act && (rx_cnt >= CW'(rx_th));
  assign tx_lvl = tx_act && (tx_cnt <= CW'(tx_th));
  // order matches status bits 6..3
  assign cond   = {ovr, udr, rx_lvl, tx_lvl};

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req <= 1'b0;
      rx_req <= 1'b0;
      irq    <= 1'b0;
    end else begin
      tx_req <= tx_lvl;
      rx_req <= rx_lvl;
      irq    <= |(cond & mask);
    end
  end
endmodule

// File: rtl/afp_regs.sv
module afp_regs
  import audio_fifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              set_ovr,
  input  logic              set_udr,
  input  logic              tx_lvl,
  input  logic              rx_lvl,
  input  logic              tx_full,
  input  logic              rx_empty,
  output ctrl_t             ctrl,
  output logic              play_dis,
  output logic              rec_dis,
  output logic [3:0]        mask,
  output logic              ovr,
  output logic              udr,
  output logic [DATA_W-1:0] csr_rdata,
  output logic              data_sel
);
  logic [7:0]        stat;
  logic [DATA_W-1:0] rd_mux;
  logic              busy;
  logic              wr_ctrl, wr_mode, wr_mask, wr_clr;
  logic              unused_hi;

  assign unused_hi = ^reg_wdata[DATA_W-1:16];
  assign wr_ctrl   = reg_wr && (reg_addr == ADR_CTRL);
  assign wr_mode   = reg_wr && (reg_addr == ADR_MODE);
  assign wr_mask   = reg_wr && (reg_addr == ADR_MASK);
  assign wr_clr    = reg_wr && (reg_addr == ADR_CLR);
  assign busy      = ctrl.en && (!play_dis || !rec_dis);

  always_comb begin
    stat        = '0;
    stat[S_OFF] = !ctrl.en;
    stat[S_OVR] = ovr;
    stat[S_UDR] = udr;
    stat[S_RSR] = rx_lvl;
    stat[S_TSR] = tx_lvl;
    stat[S_BSY] = busy;
    stat[S_RNE] = !rx_empty;
    stat[S_TNF] = !tx_full;
  end

  always_comb begin
    rd_mux = '0;
    unique case (reg_addr)
      ADR_CTRL: begin
        rd_mux[C_RTH +: TH_W] = ctrl.rx_th;
        rd_mux[C_TTH +: TH_W] = ctrl.tx_th;
        rd_mux[C_SRST]        = ctrl.srst;
        rd_mux[C_BCK]         = ctrl.bck;
        rd_mux[C_EN]          = ctrl.en;
      end
      ADR_MODE: begin
        rd_mux[M_PDIS] = play_dis;
        rd_mux[M_RDIS] = rec_dis;
      end
      ADR_STAT: rd_mux[7:0] = stat;
      ADR_MASK: rd_mux[S_OVR:S_TSR] = mask;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      play_dis  <= 1'b1;
      rec_dis   <= 1'b1;
      mask      <= '0;
      ovr       <= 1'b0;
      udr       <= 1'b0;
      csr_rdata <= '0;
      data_sel  <= 1'b0;
    end else begin
      data_sel <= reg_rd && (reg_addr == ADR_DATA);
      if (reg_rd && (reg_addr != ADR_DATA)) csr_rdata <= rd_mux;

      if (wr_ctrl) begin
        ctrl.rx_th <= reg_wdata[C_RTH +: TH_W];
        ctrl.tx_th <= reg_wdata[C_TTH +: TH_W];
        ctrl.srst  <= reg_wdata[C_SRST];
        ctrl.bck   <= reg_wdata[C_BCK];
        ctrl.en    <= reg_wdata[C_EN];
      end else if (ctrl.srst) begin
        ctrl.rx_th <= '0;
        ctrl.tx_th <= '0;
        ctrl.bck   <= 1'b0;
        ctrl.en    <= 1'b0;
      end

      if (ctrl.srst) begin
        play_dis <= 1'b1;
        rec_dis  <= 1'b1;
        mask     <= '0;
        ovr      <= 1'b0;
        udr      <= 1'b0;
      end else begin
        if (wr_mode) begin
          play_dis <= reg_wdata[M_PDIS];
          rec_dis  <= reg_wdata[M_RDIS];
        end
        if (wr_mask) mask <= reg_wdata[S_OVR:S_TSR];
        ovr <= set_ovr || (ovr && !(wr_clr && reg_wdata[S_OVR]));
        udr <= set_udr || (udr && !(wr_clr && reg_wdata[S_UDR]));
      end
    end
  end
endmodule

// File: rtl/audio_fifo_port.sv
module audio_fifo_port
  import audio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tx_pop,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_req,
  output logic              rx_req,
  output logic              irq,
  output logic              link_en,
  output logic              bclk_drive
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  ctrl_t             ctrl;
  logic              play_dis, rec_dis, ovr_q, udr_q, ctl_rst;
  logic [3:0]        mask_q;
  logic              tx_act, rx_act, tx_pop_ok, rx_push_ok;
  logic              bus_push, bus_pop;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic              tx_lvl, rx_lvl;
  logic [DATA_W-1:0] rx_dout, csr_rdata;
  logic              data_sel;

  assign ctl_rst    = ctrl.srst;
  assign tx_act     = ctrl.en && !play_dis;
  assign rx_act     = ctrl.en && !rec_dis;
  assign tx_pop_ok  = tx_pop && tx_act && !ctl_rst;
  assign rx_push_ok = rx_push && rx_act && !ctl_rst;
  assign bus_push   = reg_wr && (reg_addr == ADR_DATA) && !ctl_rst;
  assign bus_pop    = reg_rd && (reg_addr == ADR_DATA) && !ctl_rst;

  afp_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(ctl_rst),
    .push(bus_push), .din(reg_wdata),
    .pop(tx_pop_ok), .dout(tx_data),
    .count(tx_cnt), .empty(tx_empty), .full(tx_full)
  );

  afp_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(ctl_rst),
    .push(rx_push_ok), .din(rx_data),
    .pop(bus_pop), .dout(rx_dout),
    .count(rx_cnt), .empty(rx_empty), .full(rx_full)
  );

  afp_regs u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .set_ovr(rx_push_ok && rx_full), .set_udr(tx_pop_ok && tx_empty),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_full(tx_full), .rx_empty(rx_empty),
    .ctrl(ctrl), .play_dis(play_dis), .rec_dis(rec_dis), .mask(mask_q),
    .ovr(ovr_q), .udr(udr_q), .csr_rdata(csr_rdata), .data_sel(data_sel)
  );

  afp_svc #(.CW(CNT_W)) u_svc (
    .clk(clk), .rst(rst),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_th(ctrl.tx_th), .rx_th(ctrl.rx_th),
    .tx_act(tx_act), .rx_act(rx_act), .ovr(ovr_q), .udr(udr_q), .mask(mask_q),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_req(tx_req), .rx_req(rx_req), .irq(irq)
  );

  assign reg_rdata  = data_sel ? rx_dout : csr_rdata;
  assign link_en    = ctrl.en;
  assign bclk_drive = ctrl.bck;
endmodule

// File: rtl/afp_checker.sv
module afp_checker
  import audio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              tx_pop,
  input logic [DATA_W-1:0] tx_data,
  input logic              rx_push,
  input logic              irq,
  input logic [CW-1:0]     tx_cnt,
  input logic [CW-1:0]     rx_cnt,
  input logic              tx_empty,
  input logic              rx_empty,
  input logic              tx_act,
  input logic              rx_act,
  input logic              ctl_rst,
  input logic              ovr_q,
  input logic [3:0]        mask_q
);
  // R10: soft reset leaves both queues empty
  a_r10_soft_flush: assert property (@(posedge clk) disable iff (rst)
    ctl_rst |=> (tx_cnt == '0 && rx_cnt == '0));

  // R6: overrun flag holds until cleared or soft reset
  a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !ctl_rst && !(reg_wr && reg_addr == ADR_CLR && reg_wdata[S_OVR])) |=> ovr_q);

  // R7: pop from empty queue sends zeros
  a_r7_udr_zero: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && tx_act && tx_empty && !ctl_rst) |=> (tx_data == '0));

  // R9: with every mask bit clear the interrupt stays low
  a_r9_mask_gates: assert property (@(posedge clk) disable iff (rst)
    ($past(mask_q) == 4'b0) |-> !irq);

  // R3: read of empty receive queue without a push keeps it empty
  a_r3_empty_read: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == ADR_DATA && rx_empty && !rx_push) |=> rx_empty);

  // R11: with recording off the receive queue cannot grow
  a_r11_rec_off: assert property (@(posedge clk) disable iff (rst)
    (!rx_act && !ctl_rst) |=> (rx_cnt <= $past(rx_cnt)));

  // R11: with playback off the transmit word on the pins holds
  a_r11_play_off: assert property (@(posedge clk) disable iff (rst)
    (tx_pop && !tx_act && !ctl_rst) |=> $stable(tx_data));
endmodule

bind audio_fifo_port afp_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tx_pop(tx_pop), .tx_data(tx_data), .rx_push(rx_push),
  .irq(irq), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_empty(tx_empty),
  .rx_empty(rx_empty), .tx_act(tx_act), .rx_act(rx_act), .ctl_rst(ctl_rst),
  .ovr_q(ovr_q), .mask_q(mask_q)
);

// File: tb/audio_fifo_port_tb.sv
module audio_fifo_port_tb_top;
  import audio_fifo_pkg::*;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_pop = 1'b0, rx_push = 1'b0;
  logic [31:0] tx_data, rx_data = '0;
  logic        tx_req, rx_req, irq, link_en, bclk_drive;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  logic [31:0] txm[$];    // model of transmit queue contents
  logic [31:0] rxm[$];    // model of receive queue contents
  logic [31:0] tx_exp[$]; // scoreboard: expected tx_data per pop
  string       tx_tag[$];
  logic [31:0] rx_exp[$]; // scoreboard: expected data-read results
  string       rx_tag[$];
  logic [31:0] last_tx = '0;

  always #2 clk = ~clk;

  audio_fifo_port #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pop(tx_pop), .tx_data(tx_data),
    .rx_push(rx_push), .rx_data(rx_data), .tx_req(tx_req), .rx_req(rx_req),
    .irq(irq), .link_en(link_en), .bclk_drive(bclk_drive)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitors
  always @(posedge clk) begin
    if (tx_pop === 1'b1) begin
      #1;
      if (tx_exp.size() > 0) begin
        logic [31:0] e;
        string t;
        e = tx_exp.pop_front();
        t = tx_tag.pop_front();
        chk(tx_data === e, t, tx_data, e);
      end
    end
  end

  always @(posedge clk) begin
    if (reg_rd === 1'b1 && reg_addr == ADR_DATA) begin
      #1;
      if (rx_exp.size() > 0) begin
        logic [31:0] e;
        string t;
        e = rx_exp.pop_front();
        t = rx_tag.pop_front();
        chk(reg_rdata === e, t, reg_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    #1;
    d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  // driver: data write, model updated when queue has room
  task automatic put_tx(input logic [31:0] d);
    if (txm.size() < DEPTH) txm.push_back(d);
    wr(ADR_DATA, d);
  endtask

  task automatic pop_tx(input bit active, input string tag);
    logic [31:0] e;
    if (!active) e = last_tx;
    else if (txm.size() > 0) e = txm.pop_front();
    else e = '0;
    last_tx = e;
    tx_exp.push_back(e);
    tx_tag.push_back(tag);
    @(negedge clk);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic push_rx(input logic [31:0] d, input bit active);
    if (active && rxm.size() < DEPTH) rxm.push_back(d);
    @(negedge clk);
    rx_push = 1'b1; rx_data = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic get_rx(input string tag);
    logic [31:0] d;
    rx_exp.push_back(rxm.size() > 0 ? rxm.pop_front() : 32'h0);
    rx_tag.push_back(tag);
    rd(ADR_DATA, d);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(ADR_CTRL, v); chk(v == 32'h0,  "R1 ctrl", v, 32'h0);
    rd(ADR_MODE, v); chk(v == 32'h18, "R1 mode", v, 32'h18);
    rd(ADR_MASK, v); chk(v == 32'h0,  "R1 mask", v, 32'h0);
    rd(ADR_STAT, v); chk(v == 32'h81, "R1 stat", v, 32'h81);
    chk({irq, tx_req, rx_req} == 3'b000, "R1 outputs", {irq, tx_req, rx_req}, 0);

    // configure: rx th 4, tx th 2, drive bclk, enable
    wr(ADR_CTRL, 32'h0000_4205);
    wr(ADR_MODE, 32'h0);
    idle(2);
    chk({link_en, bclk_drive} == 2'b11, "R12 pins", {link_en, bclk_drive}, 2'b11);
    rd(ADR_STAT, v); chk(v == 32'h0D, "R12 R5 stat", v, 32'h0D);
    chk(tx_req == 1'b1, "R5 tx_req empty", tx_req, 1);
    chk(rx_req == 1'b0, "R4 rx_req empty", rx_req, 0);

    // R5 threshold and R2 ordering
    for (int i = 0; i < 5; i++) put_tx(32'hA000_0000 + i);
    idle(2);
    chk(tx_req == 1'b0, "R5 above threshold", tx_req, 0);
    for (int i = 0; i < 3; i++) pop_tx(1, "R2 order");
    idle(2);
    chk(tx_req == 1'b1, "R5 at threshold", tx_req, 1);
    pop_tx(1, "R2 order");
    pop_tx(1, "R2 order");
    // R7 underrun
    pop_tx(1, "R7 zero on empty");
    rd(ADR_STAT, v); chk(v[5] == 1'b1, "R7 underrun flag", v, 32'h20);

    // R2 full queue
    for (int i = 0; i < DEPTH + 1; i++) put_tx(32'hB100_0000 + i);
    rd(ADR_STAT, v); chk(v[0] == 1'b0, "R2 not-full bit when full", v, 32'h0);
    for (int i = 0; i < DEPTH; i++) pop_tx(1, "R2 full drain");
    pop_tx(1, "R2 extra word dropped");

    // R4 and R3 receive path
    for (int i = 0; i < 3; i++) push_rx(32'hC000_0000 + i, 1);
    idle(2);
    chk(rx_req == 1'b0, "R4 below threshold", rx_req, 0);
    push_rx(32'hC000_0003, 1);
    idle(2);
    chk(rx_req == 1'b1, "R4 at threshold", rx_req, 1);
    for (int i = 0; i < 4; i++) get_rx("R3 order");
    get_rx("R3 empty read zero");
    rd(ADR_STAT, v); chk(v[1] == 1'b0, "R3 not-empty bit", v, 32'h0);

    // R6 overrun
    for (int i = 0; i < DEPTH + 1; i++) push_rx(32'hD200_0000 + i, 1);
    rd(ADR_STAT, v); chk(v[6] == 1'b1, "R6 overrun flag", v, 32'h40);
    for (int i = 0; i < DEPTH; i++) get_rx("R6 kept words");
    get_rx("R6 dropped word");

    // R8 write-one-to-clear
    rd(ADR_STAT, v); chk((v & 32'h60) == 32'h60, "R8 both set", v & 32'h60, 32'h60);
    wr(ADR_CLR, 32'h20);
    rd(ADR_STAT, v); chk((v & 32'h60) == 32'h40, "R8 clear underrun only", v & 32'h60, 32'h40);
    wr(ADR_CLR, 32'h40);
    rd(ADR_STAT, v); chk((v & 32'h60) == 32'h00, "R8 clear overrun", v & 32'h60, 32'h0);

    // R9 interrupt masking
    idle(2);
    chk(irq == 1'b0, "R9 masked off", irq, 0);
    wr(ADR_MASK, 32'h08);
    idle(2);
    chk(irq == 1'b1, "R9 tx service", irq, 1);
    wr(ADR_MASK, 32'h40);
    idle(2);
    chk(irq == 1'b0, "R9 overrun masked quiet", irq, 0);
    for (int i = 0; i < DEPTH + 1; i++) push_rx(32'hE300_0000 + i, 1);
    idle(2);
    chk(irq == 1'b1, "R9 overrun irq", irq, 1);
    for (int i = 0; i < DEPTH; i++) get_rx("R9 drain");
    wr(ADR_CLR, 32'h40);
    idle(2);
    chk(irq == 1'b0, "R9 cleared", irq, 0);
    wr(ADR_MASK, 32'h0);

    // R11 recording off
    wr(ADR_MODE, 32'h08);
    push_rx(32'hF0F0_F0F0, 0);
    rd(ADR_STAT, v); chk(v[1] == 1'b0, "R11 rx ignored", v, 32'h0);
    get_rx("R11 rx ignored read");
    // R11 link off: pop ignored
    wr(ADR_CTRL, 32'h0000_4204);
    put_tx(32'h1234_5678);
    pop_tx(0, "R11 pop ignored");
    rd(ADR_STAT, v); chk(v[5] == 1'b0, "R11 no underrun", v, 32'h0);
    chk(v[7] == 1'b1, "R12 off bit", v, 32'h80);
    chk(v[2] == 1'b0, "R12 busy low when off", v, 32'h0);
    chk(link_en == 1'b0, "R12 link_en", link_en, 0);
    wr(ADR_CTRL, 32'h0000_4205);
    pop_tx(1, "R11 word kept");

    // R10 soft reset
    wr(ADR_MASK, 32'h78);
    put_tx(32'h5555_0001);
    wr(ADR_MODE, 32'h0);
    push_rx(32'h6666_0001, 1);
    wr(ADR_CTRL, 32'h0000_4208);
    idle(2);
    wr(ADR_CTRL, 32'h0);
    txm.delete(); rxm.delete();
    rd(ADR_MASK, v); chk(v == 32'h0,  "R10 mask", v, 32'h0);
    rd(ADR_MODE, v); chk(v == 32'h18, "R10 mode", v, 32'h18);
    rd(ADR_CTRL, v); chk(v == 32'h0,  "R10 ctrl", v, 32'h0);
    rd(ADR_STAT, v); chk(v == 32'h81, "R10 stat", v, 32'h81);
    get_rx("R10 rx flushed");
    idle(3);

    done = 1;
    summary();
    $finish;
  end
endmodule